// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Condition Flags

This block is the combinational integer execute unit of a small RISC pipeline. It takes two operands and a 4-bit operation code and, in the same cycle, returns a result word together with three flags: the adder carry-out, a signed overflow indication and a zero indication. The operations are add and subtract in two variants, one that may overflow and one that never does. It also provides the four bitwise functions AND, OR, XOR and NOR, and a signed and an unsigned less-than compare that yields 0 or 1.

Operands reach the block already sign- or zero-extended by the decode stage. The block raises no trap itself: the pipeline reads the overflow flag and decides what to do. Subtraction and both compares share a single adder by inverting B and forcing a carry-in of 1. A parameter selects whether that adder ripples bit by bit or resolves its carries in lookahead groups. Operation codes outside the defined set are quiet.

Top module: `intalu_top`

## Requirements
- R1: Codes 0x0 and 0x1 give result = (A + B) mod 2^WIDTH.
- R2: Codes 0x2 and 0x3 give result = (A - B) mod 2^WIDTH, computed as A + ~B + 1.
- R3: The overflow flag is 1 only for codes 0x0 and 0x2, exactly when the true signed result does not fit in WIDTH bits. It is 0 for codes 0x1 and 0x3 and for every other code.
- R4: For codes 0x0 to 0x3 the carry flag is the carry out of the top adder bit. For add that is bit WIDTH of A + B; for subtract it is 1 when A >= B unsigned. The carry flag is 0 for all other codes.
- R5: Codes 0x4, 0x5, 0x6 and 0x7 give A AND B, A OR B, A XOR B and NOT (A OR B) respectively.
- R6: Code 0xA gives result 1 when A < B as two's-complement numbers, else 0, with all upper bits 0. This holds even when A - B overflows.
- R7: Code 0xB gives result 1 when A < B as unsigned numbers, else 0, with all upper bits 0.
- R8: For the ten legal codes the zero flag is 1 exactly when every result bit is 0.
- R9: Codes 0x8, 0x9 and 0xC to 0xF give a result of 0, and the carry, overflow and zero flags are all 0.
- R10: Outputs follow the inputs with no register stage: a new operand or code is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 4 | Operation code |
| result_o | output | WIDTH | Result word |
| carry_o | output | 1 | Adder carry-out for add/sub codes |
| ovf_o | output | 1 | Signed overflow for the trapping add/sub codes |
| zero_o | output | 1 | Result-is-zero flag for legal codes |

## Verification
The bench builds the block with WIDTH = 32, and with the lookahead adder at its default group size of 4. At that width the edge operands 0x7FFFFFFF, 0x80000000, 0x80000001 and 0xFFFFFFFF can be paired under all sixteen codes. These pairings reach signed overflow in both directions, the signed compare whose difference overflows, the unsigned borrow at the top of the range and a zero result from subtracting equal values. Random operands, including forced-equal pairs, then cover carries that travel across group boundaries.

// File: rtl/intalu_pkg.sv
// Package: shared operation codes and control types for the integer ALU.
// Assumes a 4-bit operation code; codes outside the list are illegal.
package intalu_pkg;

    localparam int OP_BITS = 4;

    typedef enum logic [OP_BITS-1:0] {
        OP_ADD_TRAP = 4'h0,
        OP_ADD_WRAP = 4'h1,
        OP_SUB_TRAP = 4'h2,
        OP_SUB_WRAP = 4'h3,
        OP_AND      = 4'h4,
        OP_OR       = 4'h5,
        OP_XOR      = 4'h6,
        OP_NOR      = 4'h7,
        OP_LESS_S   = 4'hA,
        OP_LESS_U   = 4'hB
    } op_e;

    typedef enum logic [1:0] {
        UNIT_NONE  = 2'd0,
        UNIT_ARITH = 2'd1,
        UNIT_BITS  = 2'd2,
        UNIT_LESS  = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        BOP_AND = 2'd0,
        BOP_OR  = 2'd1,
        BOP_XOR = 2'd2,
        BOP_NOR = 2'd3
    } bitop_e;

    typedef struct packed {
        unit_e  unit;
        logic   invert_b;
        logic   trap_ovf;
        logic   less_signed;
        bitop_e bop;
    } ctl_t;

endpackage

// File: rtl/intalu_decode.sv
// Module: intalu_decode
// Turns the 4-bit operation code into datapath controls.
// Assumes nothing about the code value: illegal codes map to UNIT_NONE.
module intalu_decode
    import intalu_pkg::*;
(
    input  logic [OP_BITS-1:0] op_i,
    output ctl_t               ctl_o
);

    // Decode: one control word per legal code, quiet default otherwise.
    always_comb begin
        ctl_o = '{unit: UNIT_NONE, invert_b: 1'b0, trap_ovf: 1'b0,
                  less_signed: 1'b0, bop: BOP_AND};
        case (op_i)
            OP_ADD_TRAP: begin
                ctl_o.unit     = UNIT_ARITH;
                ctl_o.trap_ovf = 1'b1;
            end
            OP_ADD_WRAP: begin
                ctl_o.unit     = UNIT_ARITH;
            end
            OP_SUB_TRAP: begin
                ctl_o.unit     = UNIT_ARITH;
                ctl_o.invert_b = 1'b1;
                ctl_o.trap_ovf = 1'b1;
            end
            OP_SUB_WRAP: begin
                ctl_o.unit     = UNIT_ARITH;
                ctl_o.invert_b = 1'b1;
            end
            OP_AND: begin
                ctl_o.unit = UNIT_BITS;
                ctl_o.bop  = BOP_AND;
            end
            OP_OR: begin
                ctl_o.unit = UNIT_BITS;
                ctl_o.bop  = BOP_OR;
            end
            OP_XOR: begin
                ctl_o.unit = UNIT_BITS;
                ctl_o.bop  = BOP_XOR;
            end
            OP_NOR: begin
                ctl_o.unit = UNIT_BITS;
                ctl_o.bop  = BOP_NOR;
            end
            OP_LESS_S: begin
                ctl_o.unit        = UNIT_LESS;
                ctl_o.invert_b    = 1'b1;
                ctl_o.less_signed = 1'b1;
            end
            OP_LESS_U: begin
                ctl_o.unit     = UNIT_LESS;
                ctl_o.invert_b = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/intalu_adder.sv
// Module: intalu_adder
// Two's-complement adder/subtractor. Subtract inverts B and injects carry 1.
// Also reports the carry into the top bit so overflow can be formed outside.
// LOOKAHEAD=1 resolves carries per GROUP-bit block from group generate and
// propagate terms. LOOKAHEAD=0 ripples one bit at a time. Both are exact.
module intalu_adder #(
    parameter int WIDTH     = 32,
    parameter bit LOOKAHEAD = 1'b1,
    parameter int GROUP     = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             cmsb_o
);

    localparam int NGROUP = (WIDTH + GROUP - 1) / GROUP;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] cin_bit;
    logic             cout_w;

    // Operand conditioning and per-bit generate/propagate terms.
    always_comb begin
        b_eff = b_i ^ {WIDTH{sub_i}};
        gen   = a_i & b_eff;
        prop  = a_i ^ b_eff;
    end

    generate
        if (LOOKAHEAD) begin : g_lookahead
            // Group carries: each bit carry is G(base..k) | P(base..k) & c_group.
            always_comb begin
                logic cgrp;
                logic gacc;
                logic pacc;
                cin_bit = '0;
                cgrp    = sub_i;
                for (int gi = 0; gi < NGROUP; gi++) begin
                    gacc = 1'b0;
                    pacc = 1'b1;
                    for (int k = 0; k < GROUP; k++) begin
                        if (gi * GROUP + k < WIDTH) begin
                            cin_bit[gi*GROUP+k] = gacc | (pacc & cgrp);
                            gacc = gen[gi*GROUP+k] | (prop[gi*GROUP+k] & gacc);
                            pacc = pacc & prop[gi*GROUP+k];
                        end
                    end
                    cgrp = gacc | (pacc & cgrp);
                end
                cout_w = cgrp;
            end
        end else begin : g_ripple
            // Bit-serial carry chain from the least significant bit upward.
            always_comb begin
                logic cy;
                cin_bit = '0;
                cy      = sub_i;
                for (int i = 0; i < WIDTH; i++) begin
                    cin_bit[i] = cy;
                    cy = gen[i] | (prop[i] & cy);
                end
                cout_w = cy;
            end
        end
    endgenerate

    // Sum bits and carry outputs.
    always_comb begin
        sum_o  = prop ^ cin_bit;
        cout_o = cout_w;
        cmsb_o = cin_bit[WIDTH-1];
    end

endmodule

// File: rtl/intalu_bitwise.sv
// Module: intalu_bitwise
// Bitwise unit: AND, OR, XOR and NOR of the two operands.
// Assumes the selector comes from intalu_decode.
module intalu_bitwise
    import intalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  bitop_e           bop_i,
    output logic [WIDTH-1:0] res_o
);

    // Function select.
    always_comb begin
        unique case (bop_i)
            BOP_AND: res_o = a_i & b_i;
            BOP_OR:  res_o = a_i | b_i;
            BOP_XOR: res_o = a_i ^ b_i;
            BOP_NOR: res_o = ~(a_i | b_i);
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/intalu_top.sv
// Module: intalu_top
// Combinational integer ALU: add/sub (trapping and wrapping), bitwise ops,
// signed and unsigned less-than, with carry, overflow and zero flags.
// Assumes operands arrive already extended; no state, no clock.
module intalu_top
    import intalu_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter bit LOOKAHEAD = 1'b1,
    parameter int GROUP     = 4
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [OP_BITS-1:0] op_i,
    output logic [WIDTH-1:0]   result_o,
    output logic               carry_o,
    output logic               ovf_o,
    output logic               zero_o
);

    ctl_t             ctl;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             cmsb;
    logic [WIDTH-1:0] bits_res;
    logic             ovf_raw;
    logic             less;

    intalu_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    intalu_adder #(
        .WIDTH     (WIDTH),
        .LOOKAHEAD (LOOKAHEAD),
        .GROUP     (GROUP)
    ) u_add (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (ctl.invert_b),
        .sum_o  (sum),
        .cout_o (cout),
        .cmsb_o (cmsb)
    );

    intalu_bitwise #(
        .WIDTH (WIDTH)
    ) u_bits (
        .a_i   (a_i),
        .b_i   (b_i),
        .bop_i (ctl.bop),
        .res_o (bits_res)
    );

    // Raw overflow and less-than bit derived from the shared adder.
    always_comb begin
        ovf_raw = cmsb ^ cout;
        less    = ctl.less_signed ? (sum[WIDTH-1] ^ ovf_raw) : ~cout;
    end

    // Result select by functional unit.
    always_comb begin
        unique case (ctl.unit)
            UNIT_ARITH: result_o = sum;
            UNIT_BITS:  result_o = bits_res;
            UNIT_LESS:  result_o = {{(WIDTH-1){1'b0}}, less};
            default:    result_o = '0;
        endcase
    end

    // Flag generation, gated by the decoded unit.
    always_comb begin
        carry_o = (ctl.unit == UNIT_ARITH) & cout;
        ovf_o   = (ctl.unit == UNIT_ARITH) & ctl.trap_ovf & ovf_raw;
        zero_o  = (ctl.unit != UNIT_NONE) & (result_o == '0);
    end

endmodule

// File: rtl/intalu_chk.sv
// Module: intalu_chk
// Port-level checks for intalu_top; the block has no clock, so the checks
// are immediate assertions evaluated whenever the ports settle.
module intalu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             ovf_o,
    input logic             zero_o
);

    logic known;
    logic legal;

    // Only judge settled, fully driven inputs.
    always_comb begin
        known = !$isunknown({a_i, b_i, op_i});
        legal = (op_i <= 4'h7) || (op_i == 4'hA) || (op_i == 4'hB);
    end

    // Flag and shape checks.
    always_comb begin
        if (known) begin
            AST_NO_OVERFLOW: assert (!ovf_o || op_i == 4'h0 || op_i == 4'h2) else $error("ovf on non-trapping code"); // R3
            AST_CARRY_GATED: assert (!carry_o || op_i <= 4'h3) else $error("carry on non-adder code"); // R4
            AST_LESS_SHAPE: assert (!(op_i == 4'hA || op_i == 4'hB) || result_o[WIDTH-1:1] == '0) else $error("compare upper bits set"); // R6
            AST_LESS_UNSIGNED: assert (op_i != 4'hB || result_o[0] == (a_i < b_i)) else $error("unsigned compare wrong"); // R7
            AST_ZERO_FLAG: assert (!legal || zero_o == (result_o == '0)) else $error("zero flag wrong"); // R8
            AST_ILLEGAL_QUIET: assert (legal || (result_o == '0 && !carry_o && !ovf_o && !zero_o)) else $error("illegal code not quiet"); // R9
        end
    end

endmodule

bind intalu_top intalu_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o),
    .zero_o   (zero_o)
);

// File: tb/sim_intalu_top.sv
// Bench: behavioural reference compared against intalu_top every clock.
module sim_intalu_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   op;
    logic [W-1:0] res;
    logic         cy;
    logic         ov;
    logic         zf;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    intalu_top #(.WIDTH(W)) u0 (
        .a_i      (a),
        .b_i      (b),
        .op_i     (op),
        .result_o (res),
        .carry_o  (cy),
        .ovf_o    (ov),
        .zero_o   (zf)
    );

    // Watchdog: a hung run is one failed check, then the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'h0, 4'h1: return "R1";
            4'h2, 4'h3: return "R2";
            4'h4, 4'h5, 4'h6, 4'h7: return "R5";
            4'hA: return "R6";
            4'hB: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%h a=%h b=%h: actual=%h expected=%h", tag, op, a, b, act, exp);
        end
    endtask

    // Drive one vector after a clock edge, compare mid-period (R10: same cycle).
    task automatic run(input logic [W-1:0] av, input logic [W-1:0] bv, input logic [3:0] ov_op);
        logic [W:0]   s;
        logic [W-1:0] er;
        logic         ec;
        logic         eo;
        logic         ez;
        logic         legal;
        @(posedge clk);
        #2;
        a = av; b = bv; op = ov_op;
        #3;
        er = '0; ec = 1'b0; eo = 1'b0;
        legal = 1'b1;
        case (op)
            4'h0, 4'h1: begin
                s  = {1'b0, a} + {1'b0, b};
                er = s[W-1:0]; ec = s[W];
                if (op == 4'h0) eo = (a[W-1] == b[W-1]) && (er[W-1] != a[W-1]);
            end
            4'h2, 4'h3: begin
                s  = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
                er = s[W-1:0]; ec = s[W];
                if (op == 4'h2) eo = (a[W-1] != b[W-1]) && (er[W-1] != a[W-1]);
            end
            4'h4: er = a & b;
            4'h5: er = a | b;
            4'h6: er = a ^ b;
            4'h7: er = ~(a | b);
            4'hA: er = ($signed(a) < $signed(b)) ? W'(1) : W'(0);
            4'hB: er = (a < b) ? W'(1) : W'(0);
            default: legal = 1'b0;
        endcase
        ez = legal && (er == '0);
        check(req_of(op), res, er);
        check(legal ? "R4" : "R9", W'(cy), W'(ec));
        check(legal ? "R3" : "R9", W'(ov), W'(eo));
        check(legal ? "R8" : "R9", W'(zf), W'(ez));
    endtask

    logic [W-1:0] edges [7];

    initial begin
        edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001;
        edges[2] = 32'h7FFF_FFFF; edges[3] = 32'h8000_0000;
        edges[4] = 32'hFFFF_FFFF; edges[5] = 32'h8000_0001;
        edges[6] = 32'hAAAA_5555;
        rst_n = 1'b0; a = '0; b = '0; op = 4'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state vector: zero operands, add gives zero and zero flag (R1, R8).
        run('0, '0, 4'h0);
        // Directed: signed compare with overflowing difference (R6), true 1.
        run(32'h8000_0000, 32'h0000_0001, 4'hA);
        // Directed: trapping add overflow (R3) and wrapping add no overflow.
        run(32'h7FFF_FFFF, 32'h0000_0001, 4'h0);
        run(32'h7FFF_FFFF, 32'h0000_0001, 4'h1);
        // Directed: unsigned borrow (R7, R4).
        run(32'h0000_0000, 32'hFFFF_FFFF, 4'hB);
        run(32'h0000_0005, 32'h0000_0005, 4'h3);
        // Edge operand cross product over all codes.
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++)
                for (int k = 0; k < 16; k++)
                    run(edges[i], edges[j], 4'(k));
        // Random operands, plus forced-equal pairs.
        for (int n = 0; n < 1500; n++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = $urandom; rb = $urandom;
            for (int k = 0; k < 16; k++) begin
                run(ra, rb, 4'(k));
                if (n % 8 == 0) run(ra, ra, 4'(k));
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule